// File: doc/BRIEF.md
# Floating-Point Control and Status Word

This block keeps the control and status word that steers a SIMD floating-point datapath. The control half selects one of four rounding directions and two denormal handling options: results that come out denormal are forced to zero, and denormal inputs are read as zero. It also holds a mask bit for each of six exception classes. The status half keeps six sticky flags, one for each class.

Every operation that raises exceptions reports them on a six-bit event strobe. In the same cycle, the block tells the datapath what to do with them. If every reported class is masked, the datapath substitutes its predefined result and carries on. If any reported class is unmasked, a trap request goes to the core. The reported classes are ORed into the flags on the next clock edge. Software loads the whole word from a bus word, and the current word can always be read back on a store port.

Top module: `fpcsr_top`

## Requirements
- R1: After reset the stored word reads 0x00001F80. All six masks are set, rounding is to nearest, both denormal options are off, and every flag is clear.
- R2: The word layout is as follows. Flags sit in bits 5:0 in class order invalid=0, denormal=1, divide-by-zero=2, overflow=3, underflow=4, precision=5. Inputs-as-zero is bit 6. The masks sit in bits 12:7 in the same class order. The rounding field is bits 14:13. Flush-results-to-zero is bit 15.
- R3: When `ld_en` is high, bits 15:0 of `ld_data` become the word on the next edge. Bits 31:16 of `ld_data` are ignored, and `st_data[31:16]` always reads zero.
- R4: `round_mode` always shows bits 14:13, with the encoding 0 nearest, 1 toward minus infinity, 2 toward plus infinity, 3 toward zero. `flush_zero` shows bit 15 and `denorm_zero` shows bit 6. These fields change only on a load.
- R5: When `exc_valid` is high, each set bit of `exc_evt` sets the flag in the same position on the next edge. `exc_evt` uses the class order of R2. Several classes in one cycle all set their flags.
- R6: Flags are sticky. A cycle without a load never clears a flag.
- R7: `trap_req` is high in the same cycle whenever `exc_valid` is high and some reported class has its mask bit clear.
- R8: `use_default` is high in the same cycle whenever `exc_valid` is high, at least one class is reported, and all reported classes are masked. `use_default` and `trap_req` are never high together.
- R9: When `exc_valid` is low, neither `trap_req` nor `use_default` is high. This holds even right after a load that sets a flag whose mask is clear.
- R10: A load and an event in the same cycle produce the loaded word with the event's flags ORed in. The trap decision in that cycle uses the masks held before the load.
- R11: An event with `exc_evt` all zero changes nothing and drives neither output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_en | input | 1 | Load the word from `ld_data` |
| ld_data | input | WORD_W (32) | Bus word to load |
| st_data | output | WORD_W (32) | Current word, reserved bits zero |
| exc_valid | input | 1 | Exception report strobe |
| exc_evt | input | 6 | Reported exception classes |
| round_mode | output | 2 | Rounding direction to the datapath |
| flush_zero | output | 1 | Force denormal results to zero |
| denorm_zero | output | 1 | Read denormal inputs as zero |
| use_default | output | 1 | All reported classes masked: use predefined result |
| trap_req | output | 1 | An unmasked class was reported: trap request |

## Verification
The hardest case to reach is a load and an event in the same cycle that disagree on the masks. The trap decision must follow the old masks while the flags merge into the new word. The stimulus first loads all masks clear. Next it issues a load that sets every mask while a denormal event arrives, so a trap is expected even though the new word masks it. A following idle cycle confirms that the loaded flags with clear masks raise no trap on their own. A long pseudo-random run mixes loads and events against a behavioural model of the word.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;
   localparam int EXC_N    = 6;
   localparam int FLG_LSB  = 0;
   localparam int DAZ_POS  = 6;
   localparam int MSK_LSB  = 7;
   localparam int RND_LSB  = 13;
   localparam int FZ_POS   = 15;
   localparam int CSR_BITS = 16;
   localparam int CTL_BITS = CSR_BITS - EXC_N;

   typedef enum logic [1:0] {
      RND_NEAREST = 2'd0,
      RND_DOWN    = 2'd1,
      RND_UP      = 2'd2,
      RND_ZERO    = 2'd3
   } rnd_mode_e;

   // packed MSB first: occupies word bits 15..6
   typedef struct packed {
      logic             fz;
      rnd_mode_e        rnd;
      logic [EXC_N-1:0] msk;
      logic             daz;
   } ctl_t;
endpackage

// File: rtl/fpcsr_ctl_reg.sv
module fpcsr_ctl_reg
   import fpcsr_pkg::*;
#(
   parameter logic [EXC_N-1:0] RST_MASKS = '1,
   parameter logic [1:0]       RST_RND   = 2'd0,
   parameter bit               RST_FZ    = 1'b0,
   parameter bit               RST_DAZ   = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  ctl_t wr_val,
   output ctl_t ctl_q
);
   localparam ctl_t RST_VAL = '{fz: RST_FZ, rnd: rnd_mode_e'(RST_RND),
                                msk: RST_MASKS, daz: RST_DAZ};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ctl_q <= RST_VAL;
      else if (wr_en) ctl_q <= wr_val;
   end
endmodule

// File: rtl/fpcsr_flag_reg.sv
module fpcsr_flag_reg #(
   parameter int N         = 6,
   parameter bit MERGE_EVT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [N-1:0] wr_val,
   input  logic         evt_vld,
   input  logic [N-1:0] evt,
   output logic [N-1:0] flg_q
);
   logic [N-1:0] evt_bits;
   logic [N-1:0] flg_d;

   assign evt_bits = evt_vld ? evt : '0;

   generate
      if (MERGE_EVT) begin : g_merge
         // a load never hides an exception raised in the same cycle
         assign flg_d = (wr_en ? wr_val : flg_q) | evt_bits;
      end else begin : g_load_wins
         assign flg_d = wr_en ? wr_val : (flg_q | evt_bits);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flg_q <= '0;
      else        flg_q <= flg_d;
   end
endmodule

// File: rtl/fpcsr_decide.sv
module fpcsr_decide #(
   parameter int N = 6
) (
   input  logic         evt_vld,
   input  logic [N-1:0] evt,
   input  logic [N-1:0] msk,
   output logic         trap,
   output logic         dflt
);
   logic [N-1:0] open_bits;
   logic         any_evt;

   always_comb begin
      open_bits = evt & ~msk;
      any_evt   = evt_vld && (evt != '0);
      trap      = evt_vld && (open_bits != '0);
      dflt      = any_evt && (open_bits == '0);
   end
endmodule

// File: rtl/fpcsr_top.sv
module fpcsr_top
   import fpcsr_pkg::*;
#(
   parameter int                WORD_W          = 32,
   parameter logic [EXC_N-1:0]  RST_MASKS       = '1,
   parameter logic [1:0]        RST_RND         = 2'd0,
   parameter bit                RST_FZ          = 1'b0,
   parameter bit                RST_DAZ         = 1'b0,
   parameter bit                LOAD_MERGES_EVT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic [WORD_W-1:0] ld_data,
   output logic [WORD_W-1:0] st_data,
   input  logic              exc_valid,
   input  logic [EXC_N-1:0]  exc_evt,
   output logic [1:0]        round_mode,
   output logic              flush_zero,
   output logic              denorm_zero,
   output logic              use_default,
   output logic              trap_req
);
   localparam int PAD_W = WORD_W - CSR_BITS;

   generate
      if (WORD_W <= CSR_BITS) begin : g_bad_width
         $error("fpcsr_top: WORD_W must exceed %0d", CSR_BITS);
      end
      if (DAZ_POS != EXC_N || FZ_POS != CSR_BITS - 1) begin : g_bad_layout
         $error("fpcsr_top: control struct does not match field positions");
      end
   endgenerate

   ctl_t             ctl_q;
   logic [EXC_N-1:0] flg_q;
   ctl_t             ld_ctl;
   logic             unused_hi_bits;

   assign ld_ctl         = ctl_t'(ld_data[CSR_BITS-1:DAZ_POS]);
   assign unused_hi_bits = ^ld_data[WORD_W-1:CSR_BITS];

   fpcsr_ctl_reg #(
      .RST_MASKS (RST_MASKS),
      .RST_RND   (RST_RND),
      .RST_FZ    (RST_FZ),
      .RST_DAZ   (RST_DAZ)
   ) u_ctl (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (ld_en),
      .wr_val (ld_ctl),
      .ctl_q  (ctl_q)
   );

   fpcsr_flag_reg #(
      .N         (EXC_N),
      .MERGE_EVT (LOAD_MERGES_EVT)
   ) u_flg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (ld_en),
      .wr_val  (ld_data[FLG_LSB +: EXC_N]),
      .evt_vld (exc_valid),
      .evt     (exc_evt),
      .flg_q   (flg_q)
   );

   fpcsr_decide #(.N(EXC_N)) u_dec (
      .evt_vld (exc_valid),
      .evt     (exc_evt),
      .msk     (ctl_q.msk),
      .trap    (trap_req),
      .dflt    (use_default)
   );

   assign st_data     = {{PAD_W{1'b0}}, ctl_q, flg_q};
   assign round_mode  = ctl_q.rnd;
   assign flush_zero  = ctl_q.fz;
   assign denorm_zero = ctl_q.daz;
endmodule

// File: rtl/fpcsr_checker.sv
module fpcsr_checker
   import fpcsr_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter bit MERGE  = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ld_en,
   input logic [WORD_W-1:0] ld_data,
   input logic [WORD_W-1:0] st_data,
   input logic              exc_valid,
   input logic [EXC_N-1:0]  exc_evt,
   input logic [1:0]        round_mode,
   input logic              use_default,
   input logic              trap_req
);
   logic [EXC_N-1:0] cur_msk;
   logic [EXC_N-1:0] cur_flg;
   assign cur_msk = st_data[MSK_LSB +: EXC_N];
   assign cur_flg = st_data[FLG_LSB +: EXC_N];

   p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      st_data[WORD_W-1:CSR_BITS] == '0);

   p_load_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && !exc_valid) |=> st_data[CSR_BITS-1:0] == $past(ld_data[CSR_BITS-1:0]));

   p_ctl_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_en |=> $stable(round_mode) && $stable(st_data[CSR_BITS-1:DAZ_POS]));

   p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_valid && (MERGE || !ld_en)) |=> (cur_flg & $past(exc_evt)) == $past(exc_evt));

   p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_en |=> ($past(cur_flg) & ~cur_flg) == '0);

   p_trap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_valid && (exc_evt & ~cur_msk) != '0) |-> trap_req);

   p_default_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_valid && exc_evt != '0 && (exc_evt & ~cur_msk) == '0) |-> (use_default && !trap_req));

   p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(use_default && trap_req));

   p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !exc_valid |-> (!trap_req && !use_default));
endmodule

bind fpcsr_top fpcsr_checker #(.WORD_W(WORD_W), .MERGE(LOAD_MERGES_EVT)) u_fpcsr_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ld_en       (ld_en),
   .ld_data     (ld_data),
   .st_data     (st_data),
   .exc_valid   (exc_valid),
   .exc_evt     (exc_evt),
   .round_mode  (round_mode),
   .use_default (use_default),
   .trap_req    (trap_req)
);

// File: tb/fpcsr_top_test.sv
`timescale 1ns/1ps
module fpcsr_top_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_en = 1'b0;
   logic [31:0] ld_data = '0;
   logic [31:0] st_data;
   logic        exc_valid = 1'b0;
   logic [5:0]  exc_evt = '0;
   logic [1:0]  round_mode;
   logic        flush_zero, denorm_zero, use_default, trap_req;

   int n_run = 0;
   int n_bad = 0;
   logic [31:0] model;

   always #2.5 clk = ~clk;

   fpcsr_top uut (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_data(ld_data),
      .st_data(st_data), .exc_valid(exc_valid), .exc_evt(exc_evt),
      .round_mode(round_mode), .flush_zero(flush_zero), .denorm_zero(denorm_zero),
      .use_default(use_default), .trap_req(trap_req)
   );

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // one clock: drive after falling edge, compare outputs, advance the model at the rising edge
   task automatic step(input logic l, input logic [31:0] d,
                       input logic v, input logic [5:0] e, input string tag);
      logic [5:0]  msk;
      logic        x_trap, x_dflt;
      logic [31:0] nxt;
      @(negedge clk);
      ld_en = l; ld_data = d; exc_valid = v; exc_evt = e;
      #1;
      msk    = model[12:7];
      x_trap = v && ((e & ~msk) != 0);
      x_dflt = v && (e != 0) && !x_trap;
      check(tag, "st_data", st_data, model);
      check(tag, "trap_req", {31'd0, trap_req}, {31'd0, x_trap});
      check(tag, "use_default", {31'd0, use_default}, {31'd0, x_dflt});
      check(tag, "round_mode", {30'd0, round_mode}, {30'd0, model[14:13]});
      check(tag, "flush_zero", {31'd0, flush_zero}, {31'd0, model[15]});
      check(tag, "denorm_zero", {31'd0, denorm_zero}, {31'd0, model[6]});
      @(posedge clk);
      nxt = l ? (d & 32'h0000FFFF) : model;
      if (v) nxt = nxt | {26'd0, e};
      model = nxt;
   endtask

   task automatic idle(input string tag);
      step(1'b0, 32'h0, 1'b0, 6'h0, tag);
   endtask

   initial begin
      #100000;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] lf;
      model = 32'h0000_1F80;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1", "reset word", st_data, 32'h0000_1F80);
      idle("R1");
      // masked divide-by-zero: default result, flag bit 2 set
      step(1'b0, 0, 1'b1, 6'b000100, "R8");
      idle("R6");
      idle("R6");
      // FZ=1 RC=3 masks 110011 DAZ=1, junk in upper half
      step(1'b1, 32'hABCD_0000 | (1 << 15) | (3 << 13) | (6'b110011 << 7) | (1 << 6), 1'b0, 0, "R3");
      idle("R4");
      step(1'b0, 0, 1'b1, 6'b000100, "R7");
      step(1'b0, 0, 1'b1, 6'b100001, "R5");
      step(1'b0, 0, 1'b1, 6'b001001, "R7");
      step(1'b0, 0, 1'b1, 6'b000000, "R11");
      idle("R11");
      // all flags set, all masks clear: no trap without an event
      step(1'b1, 32'h0000_003F, 1'b0, 0, "R9");
      idle("R9");
      idle("R9");
      // load sets every mask while a denormal event arrives under the old clear masks
      step(1'b1, 32'h0000_1F80, 1'b1, 6'b000010, "R10");
      idle("R10");
      step(1'b0, 0, 1'b1, 6'b010000, "R8");
      step(1'b1, 32'h0000_1F80 | (1 << 13), 1'b0, 0, "R4");
      idle("R4");
      step(1'b1, 32'h0000_1F80 | (2 << 13), 1'b0, 0, "R4");
      idle("R4");
      step(1'b1, 32'h0000_0040, 1'b0, 0, "R2");
      step(1'b0, 0, 1'b1, 6'b000001, "R2");
      step(1'b1, 32'h0000_8000 | (6'b011111 << 7), 1'b0, 0, "R2");
      step(1'b0, 0, 1'b1, 6'b100000, "R2");
      step(1'b1, 32'h0000_1F80, 1'b0, 0, "R6");
      idle("R6");
      lf = 32'h1ACE_B00C;
      for (int i = 0; i < 400; i++) begin
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         step(lf[3:0] == 4'h0, {lf[15:0], lf[31:16]}, lf[20], lf[27:22], "R5");
      end
      idle("R6");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end
endmodule